// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block collects 96 level-sensitive interrupt inputs, grouped into three banks of 32, and presents them to a processor as one interrupt line plus a readable vector. Each source has a pending latch, an enable bit and a mask bit. All of them sit behind a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A source is eligible when it is pending, enabled and not masked. The processor line is high while any eligible source exists.

Software reads the vector register to learn which source to service. The value read is the lowest-numbered eligible source, multiplied by four. A read of zero tells software that nothing needs service, so source 0 is never reported. Software acknowledges a source by writing a one to its pending bit. Because the inputs are levels, a source whose input is still high becomes pending again on the next clock.

Two single-bit storage registers are also provided: a protection flag and an external trigger-type flag. The fast-interrupt pending words exist in the address map but no source is routed to them, so they read as zero.

Top module: `irqc_top`

## Requirements
- R1: Source n maps to bank n/32 at bit n%32. Bank b has its pending word at byte offset 0x10+4b, its enable word at 0x40+4b and its mask word at 0x50+4b.
- R2: A read of offset 0x00 returns the winning source number in bits 8:2. Bits 1:0 and all higher bits read as zero.
- R3: The vector reads zero when no source from 1 to 95 is eligible. An eligible source 0 never produces a nonzero vector and never raises the interrupt line.
- R4: When several sources are eligible, the lowest-numbered one among sources 1 to 95 is reported.
- R5: A pending bit is one on the clock after a cycle in which its input was high. Writing a 1 to a bit of a pending word clears that bit, and writing a 0 leaves it unchanged. If the input is high in the cycle of a clearing write, the bit stays set.
- R6: Enable words are full 32-bit read/write registers that reset to zero. Only sources whose enable bit is 1 take part in arbitration.
- R7: Mask words are full 32-bit read/write registers that reset to zero. A mask bit of 1 keeps its source out of arbitration and off the interrupt line.
- R8: Bit 0 of offset 0x08 (protection) and bit 0 of offset 0x0C (trigger type) are read/write storage. Their other bits read as zero, and both reset to zero.
- R9: `irq_o` is high exactly when the vector reads nonzero.
- R10: Reads of unmapped offsets and of the fast-interrupt pending words (0x20, 0x24, 0x28) return zero, and writes to them change no register. The vector register is read-only.
- R11: After reset, every register described above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| src_i | input | 96 | Level interrupt inputs; bit n is source n |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from register state |
| irq_o | output | 1 | Processor interrupt line |

## Verification
The assertions assume that `src_i`, `bus_addr`, `bus_we` and `bus_wdata` are stable around the rising edge. They also assume these inputs carry no unknown values once the internal reset has been released. The bench meets this by changing every input only at the falling edge, and by holding all inputs at zero while reset is asserted and while it is being synchronised.

Random writes draw from a fixed list of mapped and unmapped offsets. The source inputs are kept sparse so that arbitration sees one or a few contenders at a time, not a saturated request vector. Directed sequences then cover the following cases:
- source 0 alone, with no other source eligible;
- a clearing write in the same cycle as a set;
- masking;
- writes to read-only and unmapped offsets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets decoded by the register port; software depends on them.
  localparam int unsigned OFF_VECTOR = 32'h00;
  localparam int unsigned OFF_PROT   = 32'h08;
  localparam int unsigned OFF_TRIG   = 32'h0C;
  localparam int unsigned OFF_PEND   = 32'h10;
  localparam int unsigned OFF_FAST   = 32'h20;
  localparam int unsigned OFF_ENABLE = 32'h40;
  localparam int unsigned OFF_MASK   = 32'h50;
  localparam int unsigned WORD_STEP  = 4;
  // Vector value = source index shifted by this many bits.
  localparam int unsigned VEC_SHIFT  = 2;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src,
  input  logic [BANK_W-1:0] wdata,
  input  logic              we_pend,
  input  logic              we_en,
  input  logic              we_mask,
  output logic [BANK_W-1:0] pend_q,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] mask_q
);
  logic [BANK_W-1:0] clr_vec;
  logic [BANK_W-1:0] pend_d, en_d, mask_d;

  always_comb begin
    clr_vec = we_pend ? wdata : '0;
    // A live input overrides a clearing write in the same cycle.
    pend_d  = (pend_q & ~clr_vec) | src;
    en_d    = we_en   ? wdata : en_q;
    mask_d  = we_mask ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((pend_q & $past(src)) == $past(src)));                   // R5
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_pend && |(wdata & ~src)) |=> ((pend_q & $past(wdata & ~src)) == '0)); // R5
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    we_en |=> (en_q == $past(wdata)));                                    // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_mask |=> $stable(mask_q));                                        // R7
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N     = 96,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    // Scan downward so the lowest requesting index is the last assignment.
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  output logic                          irq_o
);
  localparam int unsigned NSRC  = NUM_BANKS * BANK_W;
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic                 srst_n;
  logic [NUM_BANKS-1:0] wr_pend, wr_en, wr_mask;
  logic [NSRC-1:0]      pend_all, en_all, mask_all;
  logic [NSRC-1:0]      elig, elig_arb;
  logic                 win_v;
  logic [IDX_W-1:0]     win_idx;
  logic [BANK_W-1:0]    vec_word;
  logic                 prot_q, prot_d, trig_q, trig_d;
  logic                 wr_prot, wr_trig;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wr_pend[b] = bus_we && (bus_addr == ADDR_W'(OFF_PEND   + WORD_STEP * b));
    assign wr_en[b]   = bus_we && (bus_addr == ADDR_W'(OFF_ENABLE + WORD_STEP * b));
    assign wr_mask[b] = bus_we && (bus_addr == ADDR_W'(OFF_MASK   + WORD_STEP * b));

    irqc_bank #(.BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (srst_n),
      .src     (src_i[b*BANK_W +: BANK_W]),
      .wdata   (bus_wdata),
      .we_pend (wr_pend[b]),
      .we_en   (wr_en[b]),
      .we_mask (wr_mask[b]),
      .pend_q  (pend_all[b*BANK_W +: BANK_W]),
      .en_q    (en_all[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W])
    );
  end

  // Source 0 is kept out because a zero vector means "nothing pending".
  assign elig     = pend_all & en_all & ~mask_all;
  assign elig_arb = elig & ~NSRC'(1);

  irqc_prio #(.N(NSRC), .IDX_W(IDX_W)) u_prio (
    .req   (elig_arb),
    .valid (win_v),
    .idx   (win_idx)
  );

  assign irq_o    = win_v;
  assign vec_word = BANK_W'(win_idx) << VEC_SHIFT;

  assign wr_prot = bus_we && (bus_addr == ADDR_W'(OFF_PROT));
  assign wr_trig = bus_we && (bus_addr == ADDR_W'(OFF_TRIG));

  always_comb begin
    prot_d = wr_prot ? bus_wdata[0] : prot_q;
    trig_d = wr_trig ? bus_wdata[0] : trig_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prot_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      prot_q <= prot_d;
      trig_q <= trig_d;
    end
  end

  // Read path; anything not decoded below, fast-pending words included, reads zero.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_VECTOR)) bus_rdata = vec_word;
    if (bus_addr == ADDR_W'(OFF_PROT))   bus_rdata = BANK_W'(prot_q);
    if (bus_addr == ADDR_W'(OFF_TRIG))   bus_rdata = BANK_W'(trig_q);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(OFF_PEND + WORD_STEP * b))
        bus_rdata = pend_all[b*BANK_W +: BANK_W];
      if (bus_addr == ADDR_W'(OFF_ENABLE + WORD_STEP * b))
        bus_rdata = en_all[b*BANK_W +: BANK_W];
      if (bus_addr == ADDR_W'(OFF_MASK + WORD_STEP * b))
        bus_rdata = mask_all[b*BANK_W +: BANK_W];
    end
  end

  AST_IRQ_VS_VECTOR: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o == (vec_word != '0));                                           // R9
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!srst_n)
    win_v |-> (elig_arb[win_idx] &&
               ((elig_arb & ~({NSRC{1'b1}} << win_idx)) == '0)));        // R4
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!srst_n)
    !win_v |-> (elig_arb == '0));                                         // R3
  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_prot |=> $stable(prot_q));                                        // R8
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [95:0] src;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  // Reference model state
  logic [95:0] m_pend, m_en, m_mask;
  logic        m_prot, m_trig;
  string       tag_override = "";

  always #10 clk = ~clk; // 50 MHz

  irqc_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  function automatic int m_winner();
    for (int n = 1; n < 96; n++)
      if (m_pend[n] && m_en[n] && !m_mask[n]) return n;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return 32'(m_winner() * 4);
    if (a == 8'h08) return {31'd0, m_prot};
    if (a == 8'h0C) return {31'd0, m_trig};
    for (int b = 0; b < 3; b++) begin
      if (a == 8'(8'h10 + 4 * b)) return m_pend[b*32 +: 32];
      if (a == 8'(8'h40 + 4 * b)) return m_en[b*32 +: 32];
      if (a == 8'(8'h50 + 4 * b)) return m_mask[b*32 +: 32];
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (tag_override != "") return tag_override;
    if (a == 8'h00) return "R2 R3 R4";
    if (a == 8'h08 || a == 8'h0C) return "R8";
    if (a >= 8'h10 && a <= 8'h18) return "R1 R5";
    if (a >= 8'h40 && a <= 8'h48) return "R6";
    if (a >= 8'h50 && a <= 8'h58) return "R7";
    return "R10";
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_update();
    logic [95:0] clr = '0;
    if (bus_we) begin
      for (int b = 0; b < 3; b++) begin
        if (bus_addr == 8'(8'h10 + 4 * b)) clr[b*32 +: 32] = bus_wdata;
        if (bus_addr == 8'(8'h40 + 4 * b)) m_en[b*32 +: 32] = bus_wdata;
        if (bus_addr == 8'(8'h50 + 4 * b)) m_mask[b*32 +: 32] = bus_wdata;
      end
      if (bus_addr == 8'h08) m_prot = bus_wdata[0];
      if (bus_addr == 8'h0C) m_trig = bus_wdata[0];
    end
    m_pend = (m_pend & ~clr) | src;
  endtask

  task automatic cycle(input logic [7:0] a, input logic w, input logic [31:0] d,
                       input logic [95:0] s);
    logic exp_irq;
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d; src = s;
    #5;
    check(bus_rdata === m_read(a), tag_of(a), bus_rdata, m_read(a));
    exp_irq = (m_winner() != 0);
    check(irq_o === exp_irq, (tag_override != "") ? tag_override : "R9",
          {31'd0, irq_o}, {31'd0, exp_irq});
    @(posedge clk);
    m_update();
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom_range(0, 17))
      0: return 8'h00;  1: return 8'h08;  2: return 8'h0C;
      3: return 8'h10;  4: return 8'h14;  5: return 8'h18;
      6: return 8'h40;  7: return 8'h44;  8: return 8'h48;
      9: return 8'h50;  10: return 8'h54; 11: return 8'h58;
      12: return 8'h20; 13: return 8'h24; 14: return 8'h04;
      15: return 8'h1C; 16: return 8'h60;
      default: return 8'hFC;
    endcase
  endfunction

  function automatic logic [95:0] sparse_src();
    logic [95:0] v;
    for (int b = 0; b < 3; b++)
      v[b*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_pend = '0; m_en = '0; m_mask = '0; m_prot = 1'b0; m_trig = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; src = '0;

    // R11: reset state, held and during synchroniser release
    tag_override = "R11";
    cycle(8'h00, 1'b0, '0, '0);
    cycle(8'h10, 1'b0, '0, '0);
    @(negedge clk); rst_n = 1'b1;
    foreach (m_pend[i]) ; // no-op keeps model untouched
    cycle(8'h40, 1'b0, '0, '0);
    cycle(8'h50, 1'b0, '0, '0);
    cycle(8'h08, 1'b0, '0, '0);
    cycle(8'h0C, 1'b0, '0, '0);
    cycle(8'h18, 1'b0, '0, '0);
    tag_override = "";

    // R6: enable banks
    cycle(8'h40, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h44, 1'b1, 32'h0000_0100, '0);
    cycle(8'h48, 1'b1, 32'hFFFF_FFFF, '0);
    // R3: only source 0 pending and enabled
    cycle(8'h00, 1'b0, '0, 96'd1);
    cycle(8'h00, 1'b0, '0, '0);
    cycle(8'h10, 1'b0, '0, '0);
    // R4: sources 7 and 40 together
    cycle(8'h00, 1'b0, '0, (96'd1 << 7) | (96'd1 << 40));
    cycle(8'h00, 1'b0, '0, '0);
    // R5: clear source 7 with input low
    cycle(8'h10, 1'b1, 32'h0000_0080, '0);
    cycle(8'h00, 1'b0, '0, '0);
    // R7: mask source 40
    cycle(8'h54, 1'b1, 32'h0000_0100, '0);
    cycle(8'h00, 1'b0, '0, '0);
    // R5: set wins over a full-bank clear
    cycle(8'h18, 1'b1, 32'hFFFF_FFFF, 96'd1 << 70);
    cycle(8'h18, 1'b0, '0, '0);
    cycle(8'h00, 1'b0, '0, '0);
    // R10: vector read-only, unmapped and fast words ignored
    cycle(8'h00, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h20, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h04, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h00, 1'b0, '0, '0);
    // R8: single-bit storage
    cycle(8'h08, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h0C, 1'b1, 32'hFFFF_FFFF, '0);
    cycle(8'h08, 1'b0, '0, '0);
    cycle(8'h0C, 1'b1, 32'h0000_0000, '0);
    cycle(8'h0C, 1'b0, '0, '0);

    // Random traffic: R1 R2 R4 R5 R6 R7 R9 R10 compared every cycle
    for (int k = 0; k < 6000; k++) begin
      logic [7:0] a = pick_addr();
      logic       w = ($urandom_range(0, 2) == 0);
      logic [31:0] d = $urandom;
      if (a >= 8'h10 && a <= 8'h18) d = d & $urandom;
      cycle(a, w, d, sparse_src());
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule